// File: doc/BRIEF.md
# Epoch-Flagged Hash Dictionary

This block is the match-finder memory of a sliding-window compressor. For each hash of the upcoming input bytes it keeps the most recent position at which that hash was seen. Each entry carries a one-bit block epoch next to the position, and the epoch flips at the start of every data block. An entry whose epoch differs from the current one is treated as left over from an earlier block. Because of this, the tables never need a clearing pass between blocks. Such a pass would otherwise cost one cycle per entry.

Every request is a combined lookup and insert. It carries a hash, the position of the current byte, and a collision indication from the caller. The caller sets the collision bit when it has already compared characters at the primary candidate for this hash and found a mismatch. If the primary entry belongs to the current block, the new position then goes into a separate secondary table instead of the primary one. The secondary address is the hash plus a fixed odd offset, wrapped to the table size. Otherwise the position overwrites the primary entry.

One cycle after a request the block reports what both tables held before the write. It also presents one selected candidate, taking the primary entry first. The caller must still compare characters before it accepts a candidate: an epoch match cannot tell the current block apart from the block two earlier. Table depth is 2^HASH_W. The default is kept small; 14 gives a 16K-entry table.

Top module: `epoch_hash_dict`

## Requirements
- R1: After reset, rsp_valid and cand_valid are 0 and blk_flag is 0. The first block uses epoch 0.
- R2: A cycle with blk_start high inverts blk_flag from the next cycle on. A request in that same cycle already uses the inverted epoch, for both its comparison and its write.
- R3: A request with req_valid high is answered in the next cycle with rsp_valid high. With req_valid low, rsp_valid is low in the next cycle.
- R4: pri_ok is 1 only when the primary entry at req_hash holds the epoch of the request. An entry written under the other epoch reads as invalid.
- R5: When pri_ok is 1, pri_pos is the position last written to that primary entry. This also holds when that write happened two blocks earlier under the same epoch value.
- R6: Responses show the table contents before the same request's write. A repeated request on the same hash in the next cycle returns the position written by the first request.
- R7: When req_collide is 1 and the primary entry is valid, the table entry at address (req_hash + SEC_OFS) mod 2^HASH_W is written with {epoch, req_pos}. The primary entry is left unchanged. sec_ok and sec_pos report that secondary entry under the same epoch rule as R4 and R5.
- R8: When req_collide is 0, or the primary entry is invalid, the primary entry is written and the secondary table is left unchanged.
- R9: cand_valid is pri_ok OR sec_ok. cand_pos is pri_pos when pri_ok is 1 and sec_pos otherwise.
- R10: A cycle with req_valid low writes nothing. In the next cycle pri_ok, sec_ok and cand_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Pulse that begins a new data block |
| req_valid | input | 1 | Lookup/insert request present |
| req_hash | input | HASH_W | Primary hash of the current bytes |
| req_pos | input | POS_W | Position of the current byte |
| req_collide | input | 1 | Caller found a character mismatch at the primary candidate |
| blk_flag | output | 1 | Current block epoch |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| pri_ok | output | 1 | Primary entry belongs to the current epoch |
| pri_pos | output | POS_W | Position stored in the primary entry |
| sec_ok | output | 1 | Secondary entry belongs to the current epoch |
| sec_pos | output | POS_W | Position stored in the secondary entry |
| cand_valid | output | 1 | A candidate is offered |
| cand_pos | output | POS_W | Selected candidate, primary first |

## Verification
Both tables are first filled so that every entry is known. Directed requests then try five patterns:
- back-to-back requests on one hash, which separate read-before-write from read-after-write;
- a block start in the same cycle as a request, which shows whether the new epoch is used at once;
- collision requests against a valid and against a stale primary entry, which separate the secondary write from the fallback write to the primary table;
- two successive block starts, which show that an entry from two blocks back reappears as a candidate;
- idle cycles with the other inputs toggling, which must leave both tables unchanged.

A long random run over a narrow hash range follows, with collisions, block starts and idle cycles mixed in. Its many reuses and epoch flips exercise the candidate selection order.

// File: rtl/epoch_hash_dict.sv
module epoch_hash_dict #(
  parameter int HASH_W  = 10,
  parameter int POS_W   = 16,
  parameter int SEC_OFS = 397
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              req_valid,
  input  logic [HASH_W-1:0] req_hash,
  input  logic [POS_W-1:0]  req_pos,
  input  logic              req_collide,
  output logic              blk_flag,
  output logic              rsp_valid,
  output logic              pri_ok,
  output logic [POS_W-1:0]  pri_pos,
  output logic              sec_ok,
  output logic [POS_W-1:0]  sec_pos,
  output logic              cand_valid,
  output logic [POS_W-1:0]  cand_pos
);
  localparam int DEPTH = 1 << HASH_W;
  localparam int EW    = POS_W + 1;

  logic [EW-1:0] pri_mem [DEPTH];
  logic [EW-1:0] sec_mem [DEPTH];
  logic          flag_q;

  wire              flag_now = flag_q ^ blk_start;
  wire [HASH_W-1:0] sec_addr = req_hash + HASH_W'(SEC_OFS);
  wire [EW-1:0]     p_ent    = pri_mem[req_hash];
  wire [EW-1:0]     s_ent    = sec_mem[sec_addr];
  wire              p_hit    = p_ent[POS_W] == flag_now;
  wire              s_hit    = s_ent[POS_W] == flag_now;
  wire              to_sec   = req_collide && p_hit;

  always_ff @(posedge clk) begin
    if (req_valid) begin
      if (to_sec) sec_mem[sec_addr] <= {flag_now, req_pos};
      else        pri_mem[req_hash] <= {flag_now, req_pos};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rsp_valid <= 1'b0;
      pri_ok    <= 1'b0;
      sec_ok    <= 1'b0;
      pri_pos   <= '0;
      sec_pos   <= '0;
    end else begin
      flag_q    <= flag_now;
      rsp_valid <= req_valid;
      pri_ok    <= req_valid && p_hit;
      sec_ok    <= req_valid && s_hit;
      pri_pos   <= p_ent[POS_W-1:0];
      sec_pos   <= s_ent[POS_W-1:0];
    end
  end

  assign blk_flag   = flag_q;
  assign cand_valid = pri_ok | sec_ok;
  assign cand_pos   = pri_ok ? pri_pos : sec_pos;
endmodule

// File: rtl/epoch_hash_dict_chk.sv
module epoch_hash_dict_chk #(
  parameter int HASH_W = 10,
  parameter int POS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_start,
  input logic              req_valid,
  input logic [HASH_W-1:0] req_hash,
  input logic [POS_W-1:0]  req_pos,
  input logic              req_collide,
  input logic              blk_flag,
  input logic              rsp_valid,
  input logic              pri_ok,
  input logic [POS_W-1:0]  pri_pos,
  input logic              sec_ok,
  input logic              cand_valid
);
  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  flag_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> blk_flag != $past(blk_flag));

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(blk_flag));

  // R6
  back_to_back_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_collide) && req_valid && !blk_start &&
     req_hash == $past(req_hash)) |=> (pri_ok && pri_pos == $past(req_pos, 2)));

  // R10
  idle_no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!cand_valid && !pri_ok && !sec_ok));
endmodule

bind epoch_hash_dict epoch_hash_dict_chk #(.HASH_W(HASH_W), .POS_W(POS_W)) u_chk (.*);

// File: tb/sim_epoch_hash_dict.sv
module sim_epoch_hash_dict;
  localparam int HW   = 10;
  localparam int PW   = 16;
  localparam int OFS  = 397;
  localparam int N    = 1 << HW;
  localparam int MASK = N - 1;

  logic clk = 0, rst_n = 0;
  logic blk_start = 0, req_valid = 0, req_collide = 0;
  logic [HW-1:0] req_hash = '0;
  logic [PW-1:0] req_pos = '0;
  logic blk_flag, rsp_valid, pri_ok, sec_ok, cand_valid;
  logic [PW-1:0] pri_pos, sec_pos, cand_pos;

  always #10 clk = ~clk;

  epoch_hash_dict #(.HASH_W(HW), .POS_W(PW), .SEC_OFS(OFS)) u0 (.*);

  bit          mp_f [N];
  int unsigned mp_p [N];
  bit          ms_f [N];
  int unsigned ms_p [N];
  bit          mflag;
  int checks = 0, fails = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int sec_index(input int h);
    return (h + OFS) & MASK;
  endfunction

  task automatic op(input int h, input int p, input bit col, input bit bs, input bit check);
    bit fn, epok, esok;
    int sa, epp, esp;
    fn = mflag ^ bs;
    sa = sec_index(h);
    epok = (mp_f[h] == fn);
    esok = (ms_f[sa] == fn);
    epp = mp_p[h];
    esp = ms_p[sa];
    req_valid = 1; req_hash = HW'(h); req_pos = PW'(p);
    req_collide = col; blk_start = bs;
    @(posedge clk);
    if (col && epok) begin ms_f[sa] = fn; ms_p[sa] = p; end
    else begin mp_f[h] = fn; mp_p[h] = p; end
    mflag = fn;
    @(negedge clk);
    req_valid = 0; blk_start = 0; req_collide = 0;
    if (check) begin
      chk("R3", "rsp_valid", int'(rsp_valid), 1);
      chk("R2", "blk_flag", int'(blk_flag), int'(fn));
      chk("R4", "pri_ok", int'(pri_ok), int'(epok));
      if (epok) chk("R5", "pri_pos", int'(pri_pos), epp);
      chk("R7", "sec_ok", int'(sec_ok), int'(esok));
      if (esok) chk("R7", "sec_pos", int'(sec_pos), esp);
      chk("R9", "cand_valid", int'(cand_valid), int'(epok | esok));
      if (epok | esok) chk("R9", "cand_pos", int'(cand_pos), epok ? epp : esp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      req_valid = 0; blk_start = 0;
      req_hash = HW'($urandom); req_pos = PW'($urandom); req_collide = 1'($urandom);
      @(negedge clk);
      chk("R10", "rsp_valid", int'(rsp_valid), 0);
      chk("R10", "cand_valid", int'(cand_valid), 0);
      chk("R10", "pri_ok", int'(pri_ok), 0);
    end
    req_collide = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20211));
    mflag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "cand_valid", int'(cand_valid), 0);
    chk("R1", "blk_flag", int'(blk_flag), 0);

    for (int h = 0; h < N; h++) begin
      mp_f[h] = 0; mp_p[h] = h;
      op(h, h, 0, 0, 0);
      mp_f[h] = 0; mp_p[h] = h;
      op(h, h + 1, 1, 0, 0);
    end
    for (int h = 0; h < N; h++) begin
      mp_f[h] = 0; mp_p[h] = h;
      ms_f[sec_index(h)] = 0; ms_p[sec_index(h)] = h + 1;
    end

    // R6: repeat on one hash
    op(5, 1000, 0, 0, 1);
    op(5, 1001, 0, 0, 1);
    chk("R6", "pri_pos after repeat", int'(pri_pos), 1000);
    // R2, R4: block start in same cycle as request
    op(7, 2000, 0, 1, 1);
    chk("R4", "stale primary", int'(pri_ok), 0);
    // R8: collide against stale primary goes to primary
    op(9, 2100, 1, 0, 1);
    op(9, 2101, 0, 0, 1);
    chk("R8", "fallback primary pos", int'(pri_pos), 2100);
    chk("R8", "secondary untouched", int'(sec_ok), 0);
    // R7: collide against valid primary
    op(7, 2200, 1, 0, 1);
    op(7, 2300, 0, 0, 1);
    chk("R7", "primary kept", int'(pri_pos), 2000);
    chk("R7", "secondary written", int'(sec_pos), 2200);
    chk("R9", "primary first", int'(cand_pos), 2000);
    // R5: two blocks later, epoch 0 aliases
    op(3, 2400, 0, 1, 1);
    chk("R5", "alias hit", int'(pri_ok), 1);
    chk("R5", "alias pos", int'(pri_pos), 3);
    // R10
    idle(4);
    op(20, 2500, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 10 == 0) idle(1);
      else op(int'($urandom % 24), int'($urandom & 16'hFFFF),
              ($urandom % 10) < 3, ($urandom % 32) == 0, 1);
    end
    finish_run();
  end
endmodule